// File: doc/BRIEF.md
# Probabilistic Spin Update Cell

This block holds one binary stochastic spin of a sparse Ising-style network. On each update strobe it forms the local field from up to five neighbour spins, each scaled by a signed coupling weight, plus a signed bias. It then takes the sign of that field and randomly inverts it. The chance of inversion shrinks as the field grows. The chance is set by how many unbiased pseudo-random bits are ANDed together. A small table indexed by the field magnitude and an inverse-temperature select gives that count.

A network places many of these cells side by side. It feeds each cell's registered spin to its neighbours' inputs and pulses the update strobes to suit its own schedule. The cell needs no multiplier and no tanh evaluator. It has no wide comparator against a random number.

Top module: `pbit_cell`

## Requirements
- R1: While rst_ni is low, spin_o is 1. Each of the eight 16-bit LFSR lanes loads its seed from parameter SEEDS, with lane k at bits [16k+15:16k]. A lane whose seed is zero loads 16'h0001 instead.
- R2: The local field is I = bias + Σ s_j·w_j over five neighbours. Weight j is weight_i[4j+3:4j] in two's complement, and bias_i is also two's complement. Neighbour j counts +1 when nbr_spin_i[j] is 1 and −1 when it is 0.
- R3: The field is computed without overflow over its whole range, from −48 to +47.
- R4: The sign decision is +1 when I ≥ 0 and −1 when I < 0. At I = 0 it is therefore +1.
- R5: The AND width R is 1 when I = 0. Otherwise R = min(8, |I|·2^beta_i), where beta_i is 2 bits wide.
- R6: The inversion bit is the AND of bit 15 of lanes 0 to R−1. The new spin equals the sign decision XOR that inversion bit, with spin 1 meaning +1.
- R7: On each cycle with upd_en_i high, every lane steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The inversion uses the lane values from before that step. No lane is ever zero.
- R8: spin_o is registered. It takes the new value on the clock edge at which upd_en_i is high, and otherwise it and the LFSR lanes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Update strobe |
| beta_i | input | 2 | Inverse-temperature select |
| nbr_spin_i | input | 5 | Neighbour spins, 1 = +1 |
| weight_i | input | 20 | Five 4-bit signed coupling weights |
| bias_i | input | 4 | Signed local bias |
| spin_o | output | 1 | Registered spin, 1 = +1 |

## Verification
The bench keeps its own copy of the eight LFSR lanes, built from the seeds and the step rule. It predicts every update exactly, so any skipped or extra lane step breaks all later predictions. One example is a lane that steps while the strobe is low. A zero-seeded lane would stick at zero and never allow an inversion once R reaches its index. A field of exactly zero catches a design that treats zero as negative or gives it the wrong width. The −48 and +47 extremes catch an accumulator too narrow to hold a negated −8 weight. A beta sweep at small fields catches a wrong shift, or a clamp that does not stop at 8.

// File: rtl/pbit_pkg.sv
package pbit_pkg;
  localparam int LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pbit_field.sv
module pbit_field #(
  parameter int N_NBR = 5,
  parameter int W_W   = 4,
  parameter int F_W   = 8
) (
  input  logic [N_NBR-1:0]     spin_i,
  input  logic [N_NBR*W_W-1:0] weight_i,
  input  logic [W_W-1:0]       bias_i,
  output logic [F_W-1:0]       field_o
);
  logic [F_W-1:0] acc;
  logic [F_W-1:0] term;
  logic [W_W-1:0] w;

  always_comb begin
    acc = {{(F_W-W_W){bias_i[W_W-1]}}, bias_i};
    for (int j = 0; j < N_NBR; j++) begin
      w    = weight_i[j*W_W +: W_W];
      term = {{(F_W-W_W){w[W_W-1]}}, w};
      // spin 0 means -1: negate the weight
      acc  = spin_i[j] ? acc + term : acc - term;
    end
    field_o = acc;
  end
endmodule

// File: rtl/pbit_lut.sv
module pbit_lut #(
  parameter int F_W   = 8,
  parameter int B_W   = 2,
  parameter int R_MAX = 8,
  localparam int R_W  = $clog2(R_MAX + 1),
  localparam int S_W  = F_W + (1 << B_W)
) (
  input  logic [F_W-1:0] field_i,
  input  logic [B_W-1:0] beta_i,
  output logic           sign_o,
  output logic [R_W-1:0] r_sel_o
);
  logic [F_W-1:0] mag;
  logic [S_W-1:0] scaled;

  always_comb begin
    sign_o  = ~field_i[F_W-1];
    mag     = field_i[F_W-1] ? (~field_i + 1'b1) : field_i;
    scaled  = S_W'(mag) << beta_i;
    if (mag == '0)                  r_sel_o = R_W'(1);
    else if (scaled > S_W'(R_MAX))  r_sel_o = R_W'(R_MAX);
    else                            r_sel_o = scaled[R_W-1:0];
  end
endmodule

// File: rtl/pbit_lfsr_bank.sv
module pbit_lfsr_bank
  import pbit_pkg::*;
#(
  parameter int                     N_LANE = 8,
  parameter logic [N_LANE*16-1:0]   SEEDS  = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  output logic [N_LANE-1:0]          bits_o,
  output logic [N_LANE*LFSR_W-1:0]   state_o
);
  for (genvar k = 0; k < N_LANE; k++) begin : gen_lane
    localparam logic [LFSR_W-1:0] RAW  = SEEDS[k*LFSR_W +: LFSR_W];
    localparam logic [LFSR_W-1:0] INIT = (RAW == '0) ? LFSR_W'(1) : RAW;
    logic [LFSR_W-1:0] st;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st <= INIT;
      else if (adv_i) st <= lfsr_step(st);
    end

    assign bits_o[k]                   = st[LFSR_W-1];
    assign state_o[k*LFSR_W +: LFSR_W] = st;
  end
endmodule

// File: rtl/pbit_cell.sv
module pbit_cell #(
  parameter int                  N_NBR = 5,
  parameter int                  W_W   = 4,
  parameter int                  B_W   = 2,
  parameter int                  R_MAX = 8,
  parameter logic [R_MAX*16-1:0] SEEDS = 128'h6D29_3F81_C0DE_7A5C_0000_BEEF_1234_ACE1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_en_i,
  input  logic [B_W-1:0]       beta_i,
  input  logic [N_NBR-1:0]     nbr_spin_i,
  input  logic [N_NBR*W_W-1:0] weight_i,
  input  logic [W_W-1:0]       bias_i,
  output logic                 spin_o
);
  localparam int F_W  = W_W + 1 + $clog2(N_NBR + 1);
  localparam int R_W  = $clog2(R_MAX + 1);
  localparam int FMAX = (N_NBR + 1) * (1 << (W_W - 1));

  logic [F_W-1:0]      field;
  logic                sign_d;
  logic [R_W-1:0]      r_sel;
  logic [R_MAX-1:0]    rnd_bits;
  logic [R_MAX*16-1:0] lfsr_state;
  logic [R_MAX-1:0]    used;
  logic                flip;

  pbit_field #(.N_NBR(N_NBR), .W_W(W_W), .F_W(F_W)) u_field (
    .spin_i  (nbr_spin_i),
    .weight_i(weight_i),
    .bias_i  (bias_i),
    .field_o (field)
  );

  pbit_lut #(.F_W(F_W), .B_W(B_W), .R_MAX(R_MAX)) u_lut (
    .field_i(field),
    .beta_i (beta_i),
    .sign_o (sign_d),
    .r_sel_o(r_sel)
  );

  pbit_lfsr_bank #(.N_LANE(R_MAX), .SEEDS(SEEDS)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (upd_en_i),
    .bits_o (rnd_bits),
    .state_o(lfsr_state)
  );

  // lanes at or above r_sel are forced to 1 in the AND
  for (genvar k = 0; k < R_MAX; k++) begin : gen_mask
    assign used[k] = (R_W'(k) < r_sel);
  end
  assign flip = &(rnd_bits | ~used);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       spin_o <= 1'b1;
    else if (upd_en_i) spin_o <= sign_d ^ flip;
  end
endmodule

// File: rtl/pbit_cell_chk.sv
module pbit_cell_chk #(
  parameter int F_W   = 8,
  parameter int R_W   = 4,
  parameter int R_MAX = 8,
  parameter int FMAX  = 48
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                upd_en_i,
  input logic                spin_o,
  input logic [F_W-1:0]      field,
  input logic                sign_d,
  input logic [R_W-1:0]      r_sel,
  input logic                flip,
  input logic [R_MAX*16-1:0] lfsr_state
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(spin_o));

  assert_keep_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !flip) |=> spin_o == $past(sign_d));

  assert_invert_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && flip) |=> spin_o == !$past(sign_d));

  assert_rsel_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_sel >= R_W'(1) && r_sel <= R_W'(R_MAX));

  assert_zero_field_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field == '0 |-> sign_d && r_sel == R_W'(1));

  assert_field_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(field) >= -FMAX && $signed(field) < FMAX);

  for (genvar k = 0; k < R_MAX; k++) begin : gen_lane_chk
    assert_lfsr_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lfsr_state[k*16 +: 16] != 16'h0);
  end
endmodule

bind pbit_cell pbit_cell_chk #(.F_W(F_W), .R_W(R_W), .R_MAX(R_MAX), .FMAX(FMAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .upd_en_i  (upd_en_i),
  .spin_o    (spin_o),
  .field     (field),
  .sign_d    (sign_d),
  .r_sel     (r_sel),
  .flip      (flip),
  .lfsr_state(lfsr_state)
);

// File: tb/pbit_cell_bench.sv
`timescale 1ns/1ps
module pbit_cell_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_en_i = 1'b0;
  logic [1:0]  beta_i = '0;
  logic [4:0]  nbr_spin_i = '0;
  logic [19:0] weight_i = '0;
  logic [3:0]  bias_i = '0;
  logic        spin_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] m_st [8];

  localparam logic [127:0] SEEDS = 128'h6D29_3F81_C0DE_7A5C_0000_BEEF_1234_ACE1;

  pbit_cell u_pbit_cell (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_en_i(upd_en_i), .beta_i(beta_i),
    .nbr_spin_i(nbr_spin_i), .weight_i(weight_i), .bias_i(bias_i), .spin_o(spin_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: spin_o=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic int field_of();
    int s = $signed(bias_i);
    for (int j = 0; j < 5; j++) begin
      int w = $signed(weight_i[4*j +: 4]);
      s += nbr_spin_i[j] ? w : -w;
    end
    return s;
  endfunction

  function automatic logic expect_spin();
    int f = field_of();
    int r;
    logic fl = 1'b1;
    if (f == 0) r = 1;
    else begin
      r = (f < 0 ? -f : f) << beta_i;
      if (r > 8) r = 8;
    end
    for (int k = 0; k < r; k++) fl &= m_st[k][15];
    return (f >= 0) ^ fl;
  endfunction

  task automatic upd(input string req);
    logic e = expect_spin();
    upd_en_i = 1'b1;
    @(negedge clk_i);
    upd_en_i = 1'b0;
    check(req, spin_o, e);
    for (int k = 0; k < 8; k++)
      m_st[k] = {m_st[k][14:0], m_st[k][15] ^ m_st[k][13] ^ m_st[k][12] ^ m_st[k][10]};
  endtask

  task automatic t_reset();
    check("R1 reset value", spin_o, 1'b1);
  endtask

  task automatic t_hold();
    nbr_spin_i = 5'b11111; weight_i = {5{4'h8}}; bias_i = 4'h8; beta_i = 2'd3;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      check("R8 hold without strobe", spin_o, 1'b1);
    end
  endtask

  task automatic t_zero_field();
    nbr_spin_i = 5'b10110; weight_i = '0; bias_i = '0; beta_i = 2'd3;
    for (int i = 0; i < 30; i++) upd("R4 R5 R6 zero field");
    nbr_spin_i = 5'b00011; weight_i = {4'h0, 4'h0, 4'h3, 4'h2, 4'h3}; bias_i = 4'hE;
    for (int i = 0; i < 10; i++) upd("R2 R4 cancelling field");
  endtask

  task automatic t_strong();
    nbr_spin_i = 5'b11111; weight_i = {5{4'h7}}; bias_i = 4'h7; beta_i = 2'd3;
    for (int i = 0; i < 20; i++) upd("R5 R6 strong positive");
    nbr_spin_i = 5'b00000;
    for (int i = 0; i < 20; i++) upd("R5 R6 strong negative");
  endtask

  task automatic t_extreme();
    nbr_spin_i = 5'b11111; weight_i = {5{4'h8}}; bias_i = 4'h8; beta_i = 2'd0;
    for (int i = 0; i < 10; i++) upd("R3 field -48");
    nbr_spin_i = 5'b00000; bias_i = 4'h7;
    for (int i = 0; i < 10; i++) upd("R3 field +47");
  endtask

  task automatic t_sweep();
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 24; i++) begin
        beta_i     = 2'(b);
        nbr_spin_i = 5'(i * 7 + b);
        weight_i   = {4'(i), 4'(-i), 4'(i >> 1), 4'h1, 4'(b - i)};
        bias_i     = 4'(i - 3);
        upd("R2 R5 R7 beta sweep");
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      m_st[k] = SEEDS[16*k +: 16];
      if (m_st[k] == 16'h0) m_st[k] = 16'h0001;
    end
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_hold();
    t_zero_field();
    t_strong();
    t_extreme();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule